// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Status Flags

This block computes one arithmetic, logic or single-bit shift result per cycle from two operands, and keeps six status flags in a register beside it. The result is combinational from the inputs. The flags are captured on the rising clock edge when the `exec` strobe is high, and only the flags that the selected operation defines are written. A surrounding datapath drives the operands and the operation code, reads `result` in the same cycle, and reads the flags in the cycle after the operation commits.

A width select chooses word (16-bit) or byte (low 8-bit) operation. In byte mode only the low bytes of the operands are used, the upper result byte is zero, and the carry, sign and overflow flags come from bit 7. Parity always covers the low result byte only. The nibble flag always reports the carry or borrow between bits 3 and 4.

The block has no sequencer. It has a single register stage: the flag register. Reset clears it, `exec` writes it, and it holds otherwise. This is its only transition.

Top module: `alu16_flags`

## Requirements
- R1: Operation code 0 (add) gives result = A + B + carry_in, truncated to the active width. The carry flag is the carry out of the top bit of that width.
- R2: Operation code 1 (subtract) gives result = A - B - carry_in, truncated to the active width. The carry flag is set when a borrow into the top bit is needed, and cleared otherwise.
- R3: For add, subtract, increment and decrement, the overflow flag is set exactly when the signed result does not fit in the active width.
- R4: For add, subtract, increment and decrement, the nibble flag is set on a carry from bit 3 into bit 4 (additions) or on a borrow from bit 4 into bit 3 (subtractions).
- R5: Every operation that updates status sets the zero flag when the width-masked result is zero. The sign flag copies the result's top bit (bit 15 for word, bit 7 for byte). The parity flag is set when result bits 7..0 hold an even number of ones.
- R6: With byte_mode = 1, only operand bits 7..0 are used, result bits 15..8 are zero, and carry, sign and overflow are taken at bit 7.
- R7: Operation codes 2, 3 and 4 (AND, OR, XOR of A and B) clear the carry and overflow flags, update zero, sign and parity, and leave the nibble flag unchanged.
- R8: Operation codes 5 and 6 (A + 1 and A - 1) update every flag except carry, which keeps its registered value.
- R9: Operation code 7 gives the bitwise complement of A in the active width and changes no flag.
- R10: Operation code 8 shifts A left by one and code 9 shifts A right by one (logical). The carry flag takes the bit shifted out. The overflow flag is set when the top bit of the active width changes. Zero, sign and parity are updated, and the nibble flag is unchanged.
- R11: Reset (rst_n low) clears all six flags. The flags change only on a rising clock edge with exec = 1. With exec = 0 they hold.
- R12: Operation codes 10 to 15 give a zero result and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| exec | input | 1 | Commit the selected operation's flags at the next edge |
| op | input | 4 | Operation code (0 to 9 defined, 10 to 15 reserved) |
| byte_mode | input | 1 | 1 selects 8-bit operation, 0 selects 16-bit operation |
| carry_in | input | 1 | Carry or borrow input for add and subtract |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | output | 16 | Combinational result |
| cf | output | 1 | Registered carry flag |
| pf | output | 1 | Registered parity flag |
| af | output | 1 | Registered nibble carry flag |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered sign flag |
| of | output | 1 | Registered overflow flag |

## Verification
The bench builds the block at its default data width of 16, so the same instance exercises both the word path and the byte path through `byte_mode`. At this width the directed corner operands 0x7FFF, 0x8000, 0xFFFF and 0x000F hit the signed overflow edges, the carry out of bit 15 and of bit 7, and the nibble carry boundary. Random operands with random carry-in and random `exec` then mix the flag-preserving operations with the flag-writing ones, so that stale carry and nibble values are checked while they are being held.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NOT = 4'd7,
        OP_SHL = 4'd8,
        OP_SHR = 4'd9
    } alu_op_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } flags_t;

    localparam int FLAG_N = 6;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              aux,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] ext;
    logic            sa, sb, sr;

    always_comb begin
        if (sub)
            ext = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        else
            ext = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        sum   = ext[DATA_W-1:0];
        carry = byte_mode ? ext[HALF_W] : ext[DATA_W];
        sa    = byte_mode ? a[HALF_W-1]   : a[DATA_W-1];
        sb    = byte_mode ? b[HALF_W-1]   : b[DATA_W-1];
        sr    = byte_mode ? sum[HALF_W-1] : sum[DATA_W-1];
        ovf   = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
        aux   = a[4] ^ b[4] ^ sum[4];
    end
endmodule

// File: rtl/alu16_logshift.sv
module alu16_logshift
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] res,
    output logic              shout,
    output logic              sign_chg
);
    localparam int HALF_W = DATA_W / 2;

    logic top_a, next_a;

    always_comb begin
        top_a    = byte_mode ? a[HALF_W-1] : a[DATA_W-1];
        next_a   = byte_mode ? a[HALF_W-2] : a[DATA_W-2];
        res      = '0;
        shout    = 1'b0;
        sign_chg = 1'b0;
        case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: begin
                res      = {a[DATA_W-2:0], 1'b0};
                shout    = top_a;
                sign_chg = top_a ^ next_a;
            end
            OP_SHR: begin
                res      = {1'b0, a[DATA_W-1:1]};
                shout    = a[0];
                sign_chg = top_a;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg
    import alu16_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   exec,
    input  flags_t upd,
    input  flags_t nxt,
    output flags_t q
);
    logic [FLAG_N-1:0] upd_v, nxt_v, q_v;

    assign upd_v = upd;
    assign nxt_v = nxt;
    assign q     = q_v;

    for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_v[i] <= 1'b0;
            else if (exec && upd_v[i])
                q_v[i] <= nxt_v[i];
        end
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              cf,
    output logic              pf,
    output logic              af,
    output logic              zf,
    output logic              sf,
    output logic              of
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] width_mask, a_m, b_m, as_b, as_sum, ls_res, res_raw;
    logic              as_cin, as_sub, as_carry, as_aux, as_ovf, ls_out, ls_chg;
    logic              is_arith, is_logic, is_shift, is_incdec;
    flags_t            upd, nxt, q;

    assign width_mask = byte_mode ? {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
    assign a_m = opnd_a & width_mask;
    assign b_m = opnd_b & width_mask;

    assign is_incdec = (op == OP_INC) || (op == OP_DEC);
    assign is_arith  = (op == OP_ADD) || (op == OP_SUB) || is_incdec;
    assign is_logic  = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    assign is_shift  = (op == OP_SHL) || (op == OP_SHR);

    assign as_b   = is_incdec ? {{(DATA_W-1){1'b0}}, 1'b1} : b_m;
    assign as_cin = is_incdec ? 1'b0 : carry_in;
    assign as_sub = (op == OP_SUB) || (op == OP_DEC);

    alu16_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a(a_m), .b(as_b), .cin(as_cin), .sub(as_sub), .byte_mode(byte_mode),
        .sum(as_sum), .carry(as_carry), .aux(as_aux), .ovf(as_ovf)
    );

    alu16_logshift #(.DATA_W(DATA_W)) u_logshift (
        .a(a_m), .b(b_m), .op(op), .byte_mode(byte_mode),
        .res(ls_res), .shout(ls_out), .sign_chg(ls_chg)
    );

    assign res_raw = is_arith ? as_sum : ls_res;
    assign result  = res_raw & width_mask;

    always_comb begin
        upd    = '0;
        nxt.pf = ~^result[7:0];
        nxt.zf = (result == '0);
        nxt.sf = byte_mode ? result[HALF_W-1] : result[DATA_W-1];
        nxt.af = as_aux;
        nxt.cf = 1'b0;
        nxt.of = 1'b0;
        if (is_arith) begin
            nxt.cf = as_carry;
            nxt.of = as_ovf;
            upd    = '{cf: !is_incdec, pf: 1'b1, af: 1'b1, zf: 1'b1, sf: 1'b1, of: 1'b1};
        end else if (is_logic) begin
            upd    = '{cf: 1'b1, pf: 1'b1, af: 1'b0, zf: 1'b1, sf: 1'b1, of: 1'b1};
        end else if (is_shift) begin
            nxt.cf = ls_out;
            nxt.of = ls_chg;
            upd    = '{cf: 1'b1, pf: 1'b1, af: 1'b0, zf: 1'b1, sf: 1'b1, of: 1'b1};
        end
    end

    alu16_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .exec(exec), .upd(upd), .nxt(nxt), .q(q)
    );

    assign cf = q.cf;
    assign pf = q.pf;
    assign af = q.af;
    assign zf = q.zf;
    assign sf = q.sf;
    assign of = q.of;

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> (result[DATA_W-1:HALF_W] == '0));

    a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op > 4'd9) |-> (result == '0));

    a_r12_reserved_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op > 4'd9) |=> $stable({cf, pf, af, zf, sf, of}));

    a_r9_not_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op == OP_NOT) |=> $stable({cf, pf, af, zf, sf, of}));

    a_r8_incdec_keeps_cf: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == OP_INC || op == OP_DEC)) |=> $stable(cf));

    a_r7_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> (!cf && !of && $stable(af)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable({cf, pf, af, zf, sf, of}));

    a_r5_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op <= 4'd9 && op != OP_NOT) |=> (zf == ($past(result) == '0)));
endmodule

// File: tb/alu16_flags_test.sv
module alu16_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        byte_mode = 1'b0;
    logic        carry_in = 1'b0;
    logic [15:0] opnd_a = 16'd0;
    logic [15:0] opnd_b = 16'd0;
    logic [15:0] result;
    logic        cf, pf, af, zf, sf, of;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [5:0] model_f = 6'd0;

    always #5 clk = ~clk;

    alu16_flags uut (
        .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .byte_mode(byte_mode),
        .carry_in(carry_in), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .cf(cf), .pf(pf), .af(af), .zf(zf), .sf(sf), .of(of)
    );

    function automatic int sgn(input int x, input int w);
        return (x >= (1 << (w - 1))) ? x - (1 << w) : x;
    endfunction

    function automatic bit ovr(input int t, input int w);
        return (t >= (1 << (w - 1))) || (t < -(1 << (w - 1)));
    endfunction

    // flag order {cf, pf, af, zf, sf, of}
    function automatic void model(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                                  input logic ci, input logic bmode, input logic [5:0] prev,
                                  output logic [15:0] r, output logic [5:0] fo);
        int w, mask, am, bm, rr, c_i;
        bit c, p, ax, z, s, v, touch;
        w = bmode ? 8 : 16;
        mask = (1 << w) - 1;
        am = int'(a) & mask;
        bm = int'(b) & mask;
        c_i = ci ? 1 : 0;
        {c, p, ax, z, s, v} = prev;
        touch = 1'b1;
        rr = 0;
        case (o)
            4'd0: begin
                rr = am + bm + c_i; c = rr > mask;
                ax = ((am & 15) + (bm & 15) + c_i) > 15;
                v = ovr(sgn(am, w) + sgn(bm, w) + c_i, w);
            end
            4'd1: begin
                rr = am - bm - c_i; c = rr < 0;
                ax = (am & 15) < ((bm & 15) + c_i);
                v = ovr(sgn(am, w) - sgn(bm, w) - c_i, w);
            end
            4'd2: begin rr = am & bm; c = 1'b0; v = 1'b0; end
            4'd3: begin rr = am | bm; c = 1'b0; v = 1'b0; end
            4'd4: begin rr = am ^ bm; c = 1'b0; v = 1'b0; end
            4'd5: begin rr = am + 1; ax = (am & 15) == 15; v = am == (1 << (w - 1)) - 1; end
            4'd6: begin rr = am - 1; ax = (am & 15) == 0; v = am == (1 << (w - 1)); end
            4'd7: begin rr = ~am; touch = 1'b0; end
            4'd8: begin
                c = am[w-1]; rr = am << 1; v = am[w-1] != am[w-2];
            end
            4'd9: begin c = am[0]; rr = am >> 1; v = am[w-1]; end
            default: begin rr = 0; touch = 1'b0; end
        endcase
        rr = rr & mask;
        if (touch) begin
            p = ~^rr[7:0];
            z = rr == 0;
            s = rr[w-1];
        end
        r = rr[15:0];
        fo = {c, p, ax, z, s, v};
    endfunction

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R7";
            4'd5, 4'd6: return "R8";
            4'd7: return "R9";
            4'd8, 4'd9: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input logic bmode, input logic ex, input string tag);
        logic [15:0] er;
        logic [5:0]  ef;
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; carry_in = ci; byte_mode = bmode; exec = ex;
        #1;
        model(o, a, b, ci, bmode, model_f, er, ef);
        check({tag, " result"}, result, er);
        @(posedge clk);
        #1;
        if (ex) model_f = ef;
        check({tag, " flags"}, {10'd0, cf, pf, af, zf, sf, of}, {10'd0, model_f});
        exec = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R11 reset flags", {10'd0, cf, pf, af, zf, sf, of}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        run(4'd0, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 1'b1, "R3 add overflow");
        run(4'd0, 16'hFFFF, 16'h0001, 1'b0, 1'b0, 1'b1, "R1 carry out");
        run(4'd0, 16'h000F, 16'h0001, 1'b0, 1'b0, 1'b1, "R4 nibble carry");
        run(4'd1, 16'h8000, 16'h0001, 1'b0, 1'b0, 1'b1, "R3 sub overflow");
        run(4'd1, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b1, "R2 borrow");
        run(4'd1, 16'h0010, 16'h0001, 1'b1, 1'b0, 1'b1, "R4 nibble borrow");
        run(4'd0, 16'h12FF, 16'h3401, 1'b0, 1'b1, 1'b1, "R6 byte carry");
        run(4'd0, 16'hAB7F, 16'hCD01, 1'b0, 1'b1, 1'b1, "R6 byte overflow");
        run(4'd5, 16'h7FFF, 16'h0000, 1'b0, 1'b0, 1'b1, "R8 inc keeps cf");
        run(4'd6, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, "R8 dec wrap");
        run(4'd2, 16'hFF00, 16'h00FF, 1'b0, 1'b0, 1'b1, "R5 zero result");
        run(4'd4, 16'h0103, 16'h0000, 1'b0, 1'b0, 1'b1, "R5 parity low byte");
        run(4'd7, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, "R9 complement");
        run(4'd8, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b1, "R10 shl sign change");
        run(4'd8, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1, "R10 shl carry");
        run(4'd9, 16'h0081, 16'h0000, 1'b0, 1'b1, 1'b1, "R10 shr byte");
        run(4'd12, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, "R12 reserved");
        run(4'd0, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R11 idle hold");

        // constrained random
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  ro;
            logic [15:0] ra, rb;
            logic        rb_mode, rci, rex;
            ro = 4'($urandom_range(0, 11));
            ra = 16'($urandom);
            rb = 16'($urandom);
            case ($urandom_range(0, 7))
                0: ra = 16'h7FFF;
                1: ra = 16'h8000;
                2: rb = 16'hFFFF;
                3: rb = 16'h000F;
                default: ;
            endcase
            rb_mode = 1'($urandom_range(0, 1));
            rci = 1'($urandom_range(0, 1));
            rex = ($urandom_range(0, 9) != 0);
            run(ro, ra, rb, rci, rb_mode, rex, rb_mode ? {tag_of(ro), " R6"} : tag_of(ro));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule